// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Word Error Queue

This block turns an asynchronous serial line into bytes for a host. A baud generator outside the block supplies a one-cycle enable pulse at the oversampling rate. The block uses that pulse to find the falling edge of a start bit. It confirms the start bit at its centre, then shifts in eight data bits, least significant first. An optional parity bit follows, then the stop bit. In the standard rate, each bit is sampled three times around its centre and the majority decides the value. In the two faster rates, each bit is sampled once.

Every finished word enters a queue together with three flags: parity error, framing error and line noise. The host sees the oldest word on the read port and the flags of that same word on the status outputs, and pops it with a one-cycle strobe. A receive-enable input stops reception at a word boundary. A polarity input inverts the line before any other logic sees it.

Top module: `serial_rx_flagq`

## Requirements
- R1: An idle line is high. A word is a low start bit, eight data bits sent LSB first, an optional parity bit, then a stop bit. Each bit lasts 16, 8 or 4 oversampling ticks for `rate_sel` 0, 1 or 2/3.
- R2: In the standard rate (`rate_sel`=0), each bit is sampled at ticks 7, 8 and 9 of the bit, and its value is the majority of the three samples. In the faster rates, each bit is sampled once, at tick 4 (8x) or tick 2 (4x).
- R3: If the start bit reads high at its centre, the receiver returns to idle and nothing enters the queue.
- R4: In the standard rate, a word's noise flag is set if the three samples of any of its bits disagree. Its data is still the majority value.
- R5: In the 8x and 4x rates, the noise flag is always 0.
- R6: With `par_en`=1, a parity bit is expected. The parity flag is set when the XOR of the data bits and the parity bit differs from `par_odd` (0 = even parity, 1 = odd parity). With `par_en`=0, the parity flag is 0.
- R7: The framing flag is set when the majority-sampled stop bit is low.
- R8: Words leave in arrival order. While `rd_valid` is 1, `rd_data` and the three status flags belong to the presented word. `rd_pop` removes that word, and the next word appears on the following cycle.
- R9: A word that completes while the queue holds DEPTH words is discarded. It sets `overrun`, which stays set until reset.
- R10: While `rx_enable` is 0, no new start bit is accepted. A word already in progress when `rx_enable` falls is still completed and queued.
- R11: With `rx_invert`=1, the line is complemented before start detection and sampling.
- R12: `rd_pop` while the queue is empty has no effect.
- R13: After reset, `rd_valid`, `overrun` and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oversampling tick, one cycle wide |
| rx_pin | input | 1 | Serial line input (asynchronous) |
| rx_invert | input | 1 | 1 = complement the line |
| rx_enable | input | 1 | 1 = accept new words |
| rate_sel | input | 2 | 0 = 16x, 1 = 8x, 2/3 = 4x ticks per bit |
| par_en | input | 1 | 1 = parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_pop | input | 1 | Remove the presented word |
| rd_valid | output | 1 | A word is presented |
| rd_data | output | 8 | Presented data byte |
| st_parity_err | output | 1 | Parity flag of the presented word |
| st_frame_err | output | 1 | Framing flag of the presented word |
| st_noise | output | 1 | Noise flag of the presented word |
| overrun | output | 1 | Sticky queue-overflow flag |

## Verification
Data decoding is swept across all 256 byte values in the 4x rate and across 64 spread values in the standard rate, with parity on and off. A single corrupted tick placed on a sample point and then next to the sample window separates three behaviours: the majority vote, the exact sampling ticks, and the rule that limits the noise check to the standard rate. Dedicated frames with a wrong parity bit, a low stop bit, a short start pulse, an inverted line, and `rx_enable` dropped before or during a frame each show a single flag or gating rule. A burst of mixed-flag words past the queue depth shows both that every status follows its own word and that overflow is handled.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              noise;
    } rx_word_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rxf_deser.sv
module rxf_deser
    import rxf_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_en,
    input  logic     rx_s,
    input  logic     rx_enable,
    input  logic [1:0] rate_sel,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     push,
    output rx_word_t word
);
    localparam int CW = $clog2(OVS);

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [2:0]        bidx;
        logic [DATA_W-1:0] sh;
        logic              s0;
        logic              s1;
        logic              pbit;
        logic              noise;
        logic              push;
        rx_word_t          word;
    } dsr_t;

    dsr_t q, d;
    logic [CW-1:0] last_c, half_c, dec_c;
    logic          std_rate, bitv, nz, at_dec, at_last;

    always_comb begin
        case (rate_sel)
            2'd0:    last_c = CW'(OVS - 1);
            2'd1:    last_c = CW'(OVS / 2 - 1);
            default: last_c = CW'(OVS / 4 - 1);
        endcase
        half_c   = CW'((int'(last_c) + 1) / 2);
        std_rate = (rate_sel == 2'd0);
        dec_c    = std_rate ? half_c + CW'(1) : half_c;
        at_dec   = (q.cnt == dec_c);
        at_last  = (q.cnt == last_c);
        bitv     = std_rate ? maj3(q.s0, q.s1, rx_s) : rx_s;
        nz       = std_rate && !((q.s0 == q.s1) && (q.s1 == rx_s));
    end

    always_comb begin
        d      = q;
        d.push = 1'b0;
        if (tick_en) begin
            if (q.st == ST_IDLE) begin
                if (rx_enable && !rx_s) begin
                    d.st    = ST_START;
                    d.cnt   = CW'(1);
                    d.noise = 1'b0;
                end
            end else begin
                d.cnt = at_last ? '0 : q.cnt + CW'(1);
                if (std_rate && q.cnt == half_c - CW'(1)) d.s0 = rx_s;
                if (std_rate && q.cnt == half_c)          d.s1 = rx_s;
                if (at_dec) d.noise = q.noise | nz;
                case (q.st)
                    ST_START: begin
                        if (at_dec && bitv) d.st = ST_IDLE;
                        else if (at_last) begin
                            d.st   = ST_DATA;
                            d.bidx = '0;
                        end
                    end
                    ST_DATA: begin
                        if (at_dec) d.sh = {bitv, q.sh[DATA_W-1:1]};
                        if (at_last) begin
                            if (q.bidx == 3'(DATA_W - 1)) d.st = par_en ? ST_PAR : ST_STOP;
                            else d.bidx = q.bidx + 3'd1;
                        end
                    end
                    ST_PAR: begin
                        if (at_dec)  d.pbit = bitv;
                        if (at_last) d.st = ST_STOP;
                    end
                    ST_STOP: begin
                        if (at_dec) begin
                            d.push       = 1'b1;
                            d.word.data  = q.sh;
                            d.word.perr  = par_en & ((^q.sh) ^ q.pbit ^ par_odd);
                            d.word.ferr  = !bitv;
                            d.word.noise = q.noise | nz;
                            d.st         = ST_IDLE;
                        end
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push = q.push;
    assign word = q.word;

    // A word is emitted only on the cycle after the stop bit was decided
    assert_push_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> $past(q.st) == ST_STOP);

    // Faster rates never report noise
    assert_no_noise_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.push && rate_sel != 2'd0) |-> !q.word.noise);

    // Disabled receiver stays idle
    assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !rx_enable) |=> q.st == ST_IDLE);
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  rx_word_t wdata,
    input  logic     rd_pop,
    output logic     valid,
    output rx_word_t head,
    output logic     overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]   wp;
        logic [AW-1:0]   rp;
        logic [CNTW-1:0] cnt;
        logic            ovr;
    } fq_t;

    fq_t      q, d;
    rx_word_t mem [DEPTH];
    logic     full, do_wr, do_rd;

    always_comb begin
        full  = (q.cnt == CNTW'(DEPTH));
        do_wr = wr && !full;
        do_rd = rd_pop && (q.cnt != '0);
        d     = q;
        if (do_wr) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        if (do_rd) d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        case ({do_wr, do_rd})
            2'b10:   d.cnt = q.cnt + CNTW'(1);
            2'b01:   d.cnt = q.cnt - CNTW'(1);
            default: d.cnt = q.cnt;
        endcase
        if (wr && full) d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wp] <= wdata;
    end

    assign valid   = (q.cnt != '0);
    assign head    = mem[q.rp];
    assign overrun = q.ovr;

    // A write into a full queue must not change the occupancy
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == CNTW'(DEPTH) && wr && !rd_pop) |=> q.cnt == CNTW'(DEPTH));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |=> q.ovr);

    assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == '0 && rd_pop && !wr) |=> q.cnt == '0);

    assert_pop_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0 && rd_pop && !wr) |=> q.cnt == $past(q.cnt) - CNTW'(1));
endmodule

// File: rtl/serial_rx_flagq.sv
module serial_rx_flagq
    import rxf_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       rx_pin,
    input  logic       rx_invert,
    input  logic       rx_enable,
    input  logic [1:0] rate_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_pop,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       st_parity_err,
    output logic       st_frame_err,
    output logic       st_noise,
    output logic       overrun
);
    logic     rx_s, push, valid;
    rx_word_t word, head;

    rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_pin ^ rx_invert),
        .dout (rx_s)
    );

    rxf_deser #(.OVS(OVS)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .rx_s     (rx_s),
        .rx_enable(rx_enable),
        .rate_sel (rate_sel),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .push     (push),
        .word     (word)
    );

    rxf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (push),
        .wdata  (word),
        .rd_pop (rd_pop),
        .valid  (valid),
        .head   (head),
        .overrun(overrun)
    );

    assign rd_valid      = valid;
    assign rd_data       = valid ? head.data : '0;
    assign st_parity_err = valid & head.perr;
    assign st_frame_err  = valid & head.ferr;
    assign st_noise      = valid & head.noise;
endmodule

// File: tb/tb_serial_rx_flagq.sv
module tb_serial_rx_flagq;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       rx_pin = 1'b1;
    logic       rx_invert = 1'b0;
    logic       rx_enable = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       st_parity_err, st_frame_err, st_noise, overrun;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    serial_rx_flagq #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_pin(rx_pin),
        .rx_invert(rx_invert), .rx_enable(rx_enable), .rate_sel(rate_sel),
        .par_en(par_en), .par_odd(par_odd), .rd_pop(rd_pop),
        .rd_valid(rd_valid), .rd_data(rd_data), .st_parity_err(st_parity_err),
        .st_frame_err(st_frame_err), .st_noise(st_noise), .overrun(overrun)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 195000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int bit_ticks();
        return (rate_sel == 2'd0) ? 16 : (rate_sel == 2'd1) ? 8 : 4;
    endfunction

    // Drive one tick worth of line level (logical value, inverted if needed)
    task automatic one_tick(input logic v);
        rx_pin  = v ^ rx_invert;
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) one_tick(1'b1);
    endtask

    // cbit: bit index to corrupt (0 start, 1..8 data, 9 parity, 10 stop, -1 none)
    task automatic send(input logic [7:0] dv, input logic bad_par, input logic bad_stop,
                        input int cbit, input int ctick, input int dis_bit);
        int   nt;
        logic v;
        nt = bit_ticks();
        for (int b = 0; b < 11; b++) begin
            if (b == 9 && !par_en) continue;
            if (b == dis_bit) rx_enable = 1'b0;
            if (b == 0)      v = 1'b0;
            else if (b < 9)  v = dv[b-1];
            else if (b == 9) v = (^dv) ^ par_odd ^ bad_par;
            else             v = !bad_stop;
            for (int t = 0; t < nt; t++) one_tick(v ^ (b == cbit && t == ctick));
        end
        idle_ticks(2 * nt);
    endtask

    task automatic check_head(input logic ev, input logic [7:0] ed, input logic ep,
                              input logic ef, input logic en, input string req);
        logic [11:0] act, exp;
        act = {rd_valid, rd_data, st_parity_err, st_frame_err, st_noise};
        exp = {ev, ed, ep, ef, en};
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual v=%b d=%h p=%b f=%b n=%b expected v=%b d=%h p=%b f=%b n=%b",
                     req, act[11], act[10:3], act[2], act[1], act[0],
                     ev, ed, ep, ef, en);
        end
    endtask

    task automatic check_bit(input logic a, input logic e, input string req);
        n_chk = n_chk + 1;
        if (a !== e) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %b expected %b", req, a, e);
        end
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        logic [7:0] dv;
        repeat (3) @(negedge clk);
        // R13 reset state
        check_head(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R13 reset");
        check_bit(overrun, 1'b0, "R13 reset overrun");
        rst_n = 1'b1;
        idle_ticks(4);

        // R1 R2 R6: standard rate sweep, parity varied, clean frames
        for (int i = 0; i < 64; i++) begin
            dv      = 8'((i * 73 + 5) & 255);
            par_en  = i[0];
            par_odd = i[1];
            send(dv, 1'b0, 1'b0, -1, 0, -1);
            check_head(1'b1, dv, 1'b0, 1'b0, 1'b0, "R1 16x sweep");
            pop();
            check_bit(rd_valid, 1'b0, "R8 empty after pop");
        end

        // R1 R5: 4x rate, all bytes; odd ones get a non-sample tick corrupted
        rate_sel = 2'd2;
        par_en   = 1'b0;
        for (int i = 0; i < 256; i++) begin
            send(8'(i), 1'b0, 1'b0, (i % 2 == 1) ? 1 + (i % 8) : -1, 1, -1);
            check_head(1'b1, 8'(i), 1'b0, 1'b0, 1'b0, "R1 R5 4x sweep");
            pop();
        end

        // R2 R5: 8x rate, ticks next to the single sample corrupted
        rate_sel = 2'd1;
        send(8'hA5, 1'b0, 1'b0, 3, 3, -1);
        check_head(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, "R5 8x tick3");
        pop();
        send(8'h3C, 1'b0, 1'b0, 6, 5, -1);
        check_head(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, "R5 8x tick5");
        pop();

        // R2 R4: standard rate, one corrupted sample per data bit
        rate_sel = 2'd0;
        for (int b = 1; b <= 8; b++) begin
            send(8'h96, 1'b0, 1'b0, b, 7 + (b % 3), -1);
            check_head(1'b1, 8'h96, 1'b0, 1'b0, 1'b1, "R4 noise majority");
            pop();
        end
        // R2: corruption just outside the sample window is not noise
        send(8'h5A, 1'b0, 1'b0, 4, 6, -1);
        check_head(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, "R2 tick6 outside");
        pop();
        send(8'h5A, 1'b0, 1'b0, 5, 10, -1);
        check_head(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, "R2 tick10 outside");
        pop();
        // R4: noise on the stop bit
        send(8'h11, 1'b0, 1'b0, 10, 9, -1);
        check_head(1'b1, 8'h11, 1'b0, 1'b0, 1'b1, "R4 stop noise");
        pop();

        // R6 parity errors, even and odd
        par_en = 1'b1;
        par_odd = 1'b0;
        send(8'h07, 1'b1, 1'b0, -1, 0, -1);
        check_head(1'b1, 8'h07, 1'b1, 1'b0, 1'b0, "R6 even bad");
        pop();
        par_odd = 1'b1;
        send(8'h80, 1'b1, 1'b0, -1, 0, -1);
        check_head(1'b1, 8'h80, 1'b1, 1'b0, 1'b0, "R6 odd bad");
        pop();
        par_en = 1'b0;

        // R7 framing
        send(8'hC3, 1'b0, 1'b1, -1, 0, -1);
        check_head(1'b1, 8'hC3, 1'b0, 1'b1, 1'b0, "R7 low stop");
        pop();
        idle_ticks(32);
        check_bit(rd_valid, 1'b0, "R3 no word after framing tail");

        // R3 false start
        for (int t = 0; t < 6; t++) one_tick(1'b0);
        idle_ticks(48);
        check_bit(rd_valid, 1'b0, "R3 false start");

        // R11 inverted line
        rx_invert = 1'b1;
        idle_ticks(4);
        send(8'h6E, 1'b0, 1'b0, -1, 0, -1);
        check_head(1'b1, 8'h6E, 1'b0, 1'b0, 1'b0, "R11 invert");
        pop();
        rx_invert = 1'b0;
        idle_ticks(4);

        // R10 disabled before the frame: ignored
        rx_enable = 1'b0;
        send(8'h42, 1'b0, 1'b0, -1, 0, -1);
        check_bit(rd_valid, 1'b0, "R10 disabled");
        // R10 disable during a frame: completes
        rx_enable = 1'b1;
        send(8'h24, 1'b0, 1'b0, -1, 0, 3);
        check_head(1'b1, 8'h24, 1'b0, 1'b0, 1'b0, "R10 finish current");
        pop();
        rx_enable = 1'b1;

        // R12 pop on empty, then a word still arrives intact
        pop();
        pop();
        check_bit(rd_valid, 1'b0, "R12 empty pop");
        send(8'hE1, 1'b0, 1'b0, -1, 0, -1);
        check_head(1'b1, 8'hE1, 1'b0, 0, 0, "R12 after empty pop");
        pop();

        // R8 R9: mixed flags, fill past depth
        par_en = 1'b1;
        par_odd = 1'b0;
        send(8'h01, 1'b0, 1'b0, -1, 0, -1);
        send(8'h02, 1'b1, 1'b0, -1, 0, -1);
        send(8'h03, 1'b0, 1'b0, 2, 8, -1);
        send(8'h04, 1'b0, 1'b1, -1, 0, -1);
        idle_ticks(16);
        check_bit(overrun, 1'b0, "R9 not yet overrun");
        send(8'h05, 1'b0, 1'b0, -1, 0, -1);
        check_bit(overrun, 1'b1, "R9 overrun set");
        check_head(1'b1, 8'h01, 1'b0, 1'b0, 1'b0, "R8 word1");
        pop();
        check_head(1'b1, 8'h02, 1'b1, 1'b0, 1'b0, "R8 word2");
        pop();
        check_head(1'b1, 8'h03, 1'b0, 1'b0, 1'b1, "R8 word3");
        pop();
        check_head(1'b1, 8'h04, 1'b0, 1'b1, 1'b0, "R8 word4");
        pop();
        check_head(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9 word5 dropped");
        check_bit(overrun, 1'b1, "R9 overrun sticky");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule